// File: doc/BRIEF.md
# Initiator Message-Out Byte Sender

This block runs the initiator side of the message-out phase on a parallel SCSI bus. A controlling state machine loads a small message buffer (a length and up to eight bytes). Loading a non-empty message raises the attention line (ATN) to ask the target for a message-out phase. When the target enters that phase, the controller pulses a start input. The block then hands the bytes one at a time to the bus handshake logic. Each byte appears on a data output with a one-cycle strobe, and the bus handshake logic answers with an acknowledge.

ATN is lowered while the final byte goes out. After that byte, the block watches the bus. A further REQ while the target is still in message-out is a request to send the message again, so the block raises ATN once more and keeps the buffer. A phase change or bus free instead ends the message and empties the buffer. If the target moves to another phase part way through, the block lowers ATN, empties the buffer and reports a mismatch. A start that finds the buffer empty sends a one-byte no-operation message instead. Every exit is reported to the controller with a one-cycle done pulse and a reason code.

Top module: `msgout_sender`

## Requirements
- R1: While reset is held, and in the cycle after it is released, ATN, the byte strobe and done are low and the reported buffer length is 0.
- R2: A load stores the bytes (byte i taken from load bits 8i+7..8i) and the length, which is clamped to 8 when larger. A load with a non-zero length raises ATN in the cycle after the load.
- R3: A start that finds the buffer length at 0 loads the single byte 0x08 (no-operation), reports length 1 and sends that byte.
- R4: Bytes go out in buffer order starting at index 0. There is one strobe of exactly one cycle per byte, each strobe follows a REQ seen in phase message-out (phase code 3'b110, bits MSG, C/D, I/O), and the byte stays on the output until the next strobe.
- R5: ATN is low in the cycle the last byte is strobed, and high for every earlier byte of the message.
- R6: A phase other than 3'b110, whether seen while waiting for REQ or in the cycle a byte is about to be issued, ends the transfer. No further strobe is given, ATN goes low, the length becomes 0, and done pulses with reason 2'd1 (mismatch).
- R7: After the last byte, a REQ with phase 3'b110 raises ATN and pulses done with reason 2'd3 (resend). The buffer length is kept, and a following start sends the same bytes again.
- R8: After the last byte, a REQ with any other phase pulses done with reason 2'd0 (sent) and clears the length.
- R9: After the last byte, bus free pulses done with reason 2'd2 (bus free) and clears the length.
- R10: Done is high for exactly one cycle per exit. A start pulse that arrives while a transfer is in progress has no effect on the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Write the message buffer |
| load_len_i | input | 4 | Message length for the load |
| load_bytes_i | input | 64 | Message bytes, byte i at bits 8i+7..8i |
| start_i | input | 1 | Target has entered message-out; begin sending |
| phase_i | input | 3 | Bus phase {MSG, C/D, I/O}; 3'b110 is message-out |
| req_i | input | 1 | Target REQ, byte requested |
| busfree_i | input | 1 | Bus free detected |
| ack_i | input | 1 | Handshake logic has taken the presented byte |
| msg_byte_o | output | 8 | Byte being presented |
| msg_stb_o | output | 1 | One-cycle strobe for a new byte |
| atn_o | output | 1 | Attention line request |
| done_o | output | 1 | One-cycle exit pulse |
| reason_o | output | 2 | Exit reason: 0 sent, 1 mismatch, 2 bus free, 3 resend |
| msg_len_o | output | 4 | Current buffer length |

## Verification
The sender is tried with several kinds of message: a three-byte message, an eight-byte message loaded with an over-long length, a single-byte message, and a start with an empty buffer. Together these separate correct index order and correct last-byte ATN timing from off-by-one counting, and show that the no-operation fill happens only when the buffer is empty. The phase-change tests interrupt the transfer at two points, once while waiting for REQ and once in the issue cycle after REQ. Each point exercises one of the two mismatch checks. The tail of the message is ended three ways: REQ in message-out, REQ in another phase, and bus free. These tell resend apart from normal completion, both by the reason code and by whether ATN and the buffer length survive.

// File: rtl/msgout_pkg.sv
package msgout_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned MSG_DEPTH   = 8;
    localparam logic [BYTE_W-1:0] NOP_CODE = 8'h08;
    localparam logic [2:0]  PH_MSG_OUT  = 3'b110;

    typedef logic [BYTE_W-1:0] msg_byte_t;

    typedef enum logic [1:0] {
        RSN_SENT     = 2'd0,
        RSN_MISMATCH = 2'd1,
        RSN_BUSFREE  = 2'd2,
        RSN_RESEND   = 2'd3
    } reason_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_ISSUE,
        ST_WAIT_ACK,
        ST_SNOOP
    } seq_state_e;

    typedef struct packed {
        logic    valid;
        reason_e why;
    } exit_t;

    typedef struct packed {
        logic fill_nop;
        logic clear;
    } buf_cmd_t;

    function automatic logic phase_is_msgout(input logic [2:0] ph);
        return ph == PH_MSG_OUT;
    endfunction

endpackage

// File: rtl/msgout_buffer.sv
module msgout_buffer
    import msgout_pkg::*;
#(
    parameter int unsigned DEPTH = MSG_DEPTH,
    parameter int unsigned LEN_W = $clog2(DEPTH + 1),
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [LEN_W-1:0]        load_len_i,
    input  logic [DEPTH*BYTE_W-1:0] load_bytes_i,
    input  buf_cmd_t                cmd_i,
    input  logic [IDX_W-1:0]        rd_idx_i,
    output logic [LEN_W-1:0]        len_o,
    output msg_byte_t               rd_byte_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_clamped;
    msg_byte_t        entry_q [DEPTH];

    assign len_clamped = (load_len_i > LEN_MAX) ? LEN_MAX : load_len_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (cmd_i.clear) begin
            len_q <= '0;
        end else if (cmd_i.fill_nop) begin
            len_q <= LEN_ONE;
        end else if (load_i) begin
            len_q <= len_clamped;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    entry_q[g] <= '0;
                end else if (cmd_i.fill_nop) begin
                    entry_q[g] <= NOP_CODE;
                end else if (load_i) begin
                    entry_q[g] <= load_bytes_i[g*BYTE_W +: BYTE_W];
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    entry_q[g] <= '0;
                end else if (load_i && !cmd_i.fill_nop) begin
                    entry_q[g] <= load_bytes_i[g*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign len_o     = len_q;
    assign rd_byte_o = entry_q[rd_idx_i];

endmodule

// File: rtl/msgout_atn.sv
module msgout_atn (
    input  logic clk,
    input  logic rst,
    input  logic load_nonempty_i,
    input  logic resend_i,
    input  logic drop_i,
    output logic atn_o
);

    logic atn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            atn_q <= 1'b0;
        end else if (drop_i) begin
            atn_q <= 1'b0;
        end else if (load_nonempty_i || resend_i) begin
            atn_q <= 1'b1;
        end
    end

    assign atn_o = atn_q;

endmodule

// File: rtl/msgout_seq.sv
module msgout_seq
    import msgout_pkg::*;
#(
    parameter int unsigned DEPTH = MSG_DEPTH,
    parameter int unsigned LEN_W = $clog2(DEPTH + 1),
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [2:0]       phase_i,
    input  logic             req_i,
    input  logic             busfree_i,
    input  logic             ack_i,
    input  logic [LEN_W-1:0] len_i,
    input  msg_byte_t        rd_byte_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output buf_cmd_t         buf_cmd_o,
    output logic             atn_drop_o,
    output logic             resend_o,
    output logic             last_byte_o,
    output msg_byte_t        byte_o,
    output logic             stb_o,
    output logic             done_o,
    output reason_e          reason_o
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic [IDX_W-1:0] idx_q;
    msg_byte_t        byte_q;
    logic             stb_q;
    logic             done_q;
    reason_e          why_q;

    logic  mismatch;
    logic  last;
    logic  issue;
    logic  advance;
    logic  fill;
    exit_t ext;

    assign mismatch = !phase_is_msgout(phase_i);
    assign last     = (rem_q == LEN_ONE);

    always_comb begin
        state_d   = state_q;
        ext       = '{valid: 1'b0, why: RSN_SENT};
        issue     = 1'b0;
        advance   = 1'b0;
        fill      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    fill    = (len_i == '0);
                    state_d = ST_WAIT_REQ;
                end
            end
            ST_WAIT_REQ: begin
                if (mismatch) begin
                    ext     = '{valid: 1'b1, why: RSN_MISMATCH};
                    state_d = ST_IDLE;
                end else if (req_i) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mismatch) begin
                    ext     = '{valid: 1'b1, why: RSN_MISMATCH};
                    state_d = ST_IDLE;
                end else begin
                    issue   = 1'b1;
                    state_d = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_i) begin
                    advance = 1'b1;
                    state_d = last ? ST_SNOOP : ST_WAIT_REQ;
                end
            end
            ST_SNOOP: begin
                if (busfree_i) begin
                    ext     = '{valid: 1'b1, why: RSN_BUSFREE};
                    state_d = ST_IDLE;
                end else if (req_i) begin
                    ext     = mismatch ? '{valid: 1'b1, why: RSN_SENT}
                                       : '{valid: 1'b1, why: RSN_RESEND};
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            idx_q   <= '0;
            byte_q  <= '0;
            stb_q   <= 1'b0;
            done_q  <= 1'b0;
            why_q   <= RSN_SENT;
        end else begin
            state_q <= state_d;
            stb_q   <= issue;
            done_q  <= ext.valid;
            if (ext.valid) begin
                why_q <= ext.why;
            end
            if (state_q == ST_IDLE && start_i) begin
                rem_q <= (len_i == '0) ? LEN_ONE : len_i;
                idx_q <= '0;
            end else if (advance) begin
                rem_q <= rem_q - LEN_ONE;
                idx_q <= idx_q + IDX_W'(1);
            end
            if (issue) begin
                byte_q <= rd_byte_i;
            end
        end
    end

    assign rd_idx_o           = idx_q;
    assign buf_cmd_o.fill_nop = fill;
    assign buf_cmd_o.clear    = ext.valid && (ext.why != RSN_RESEND);
    assign atn_drop_o         = (issue && last) ||
                                (ext.valid && ext.why == RSN_MISMATCH);
    assign resend_o           = ext.valid && (ext.why == RSN_RESEND);
    assign last_byte_o        = last;
    assign byte_o             = byte_q;
    assign stb_o              = stb_q;
    assign done_o             = done_q;
    assign reason_o           = why_q;

endmodule

// File: rtl/msgout_sender.sv
module msgout_sender
    import msgout_pkg::*;
#(
    parameter int unsigned DEPTH = MSG_DEPTH,
    parameter int unsigned LEN_W = $clog2(DEPTH + 1),
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [LEN_W-1:0]        load_len_i,
    input  logic [DEPTH*BYTE_W-1:0] load_bytes_i,
    input  logic                    start_i,
    input  logic [2:0]              phase_i,
    input  logic                    req_i,
    input  logic                    busfree_i,
    input  logic                    ack_i,
    output logic [BYTE_W-1:0]       msg_byte_o,
    output logic                    msg_stb_o,
    output logic                    atn_o,
    output logic                    done_o,
    output logic [1:0]              reason_o,
    output logic [LEN_W-1:0]        msg_len_o
);

    buf_cmd_t         buf_cmd;
    logic [IDX_W-1:0] rd_idx;
    msg_byte_t        rd_byte;
    logic [LEN_W-1:0] buf_len;
    logic             atn_drop;
    logic             resend;
    logic             last_byte;
    reason_e          reason;
    msg_byte_t        seq_byte;

    msgout_buffer #(
        .DEPTH (DEPTH),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) i_buffer (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .load_len_i   (load_len_i),
        .load_bytes_i (load_bytes_i),
        .cmd_i        (buf_cmd),
        .rd_idx_i     (rd_idx),
        .len_o        (buf_len),
        .rd_byte_o    (rd_byte)
    );

    msgout_seq #(
        .DEPTH (DEPTH),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .phase_i     (phase_i),
        .req_i       (req_i),
        .busfree_i   (busfree_i),
        .ack_i       (ack_i),
        .len_i       (buf_len),
        .rd_byte_i   (rd_byte),
        .rd_idx_o    (rd_idx),
        .buf_cmd_o   (buf_cmd),
        .atn_drop_o  (atn_drop),
        .resend_o    (resend),
        .last_byte_o (last_byte),
        .byte_o      (seq_byte),
        .stb_o       (msg_stb_o),
        .done_o      (done_o),
        .reason_o    (reason)
    );

    msgout_atn i_atn (
        .clk             (clk),
        .rst             (rst),
        .load_nonempty_i (load_i && (load_len_i != '0)),
        .resend_i        (resend),
        .drop_i          (atn_drop),
        .atn_o           (atn_o)
    );

    assign msg_byte_o = seq_byte;
    assign reason_o   = reason;
    assign msg_len_o  = buf_len;

endmodule

// File: rtl/msgout_sender_chk.sv
module msgout_sender_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LEN_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_stb_o,
    input logic [7:0]       msg_byte_o,
    input logic             atn_o,
    input logic             done_o,
    input logic [1:0]       reason_o,
    input logic [LEN_W-1:0] msg_len_o,
    input logic             last_byte
);

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        msg_len_o <= LEN_W'(DEPTH)); // R2

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        msg_stb_o |=> !msg_stb_o); // R4

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
        !$rose(msg_stb_o) |-> $stable(msg_byte_o)); // R4

    AST_LAST_NO_ATN: assert property (@(posedge clk) disable iff (rst)
        (msg_stb_o && last_byte) |-> !atn_o); // R5

    AST_MISMATCH_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (done_o && reason_o == 2'd1) |-> (!atn_o && msg_len_o == '0)); // R6

    AST_RESEND_ATN: assert property (@(posedge clk) disable iff (rst)
        (done_o && reason_o == 2'd3) |-> (atn_o && msg_len_o != '0)); // R7

    AST_SENT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (done_o && reason_o == 2'd0) |-> msg_len_o == '0); // R8

    AST_BUSFREE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (done_o && reason_o == 2'd2) |-> msg_len_o == '0); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

endmodule

bind msgout_sender msgout_sender_chk #(
    .DEPTH (DEPTH),
    .LEN_W (LEN_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_stb_o  (msg_stb_o),
    .msg_byte_o (msg_byte_o),
    .atn_o      (atn_o),
    .done_o     (done_o),
    .reason_o   (reason_o),
    .msg_len_o  (msg_len_o),
    .last_byte  (last_byte)
);

// File: tb/test_msgout_sender.sv
`timescale 1ns/1ps
module test_msgout_sender;

    localparam logic [2:0] PH_MO = 3'b110;
    localparam logic [2:0] PH_MI = 3'b111;

    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [3:0]  load_len;
    logic [63:0] load_bytes;
    logic        start;
    logic [2:0]  phase;
    logic        req;
    logic        busfree;
    logic        ack;
    logic [7:0]  msg_byte;
    logic        msg_stb;
    logic        atn;
    logic        done;
    logic [1:0]  reason;
    logic [3:0]  msg_len;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    msgout_sender i_msgout_sender (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .load_len_i   (load_len),
        .load_bytes_i (load_bytes),
        .start_i      (start),
        .phase_i      (phase),
        .req_i        (req),
        .busfree_i    (busfree),
        .ack_i        (ack),
        .msg_byte_o   (msg_byte),
        .msg_stb_o    (msg_stb),
        .atn_o        (atn),
        .done_o       (done),
        .reason_o     (reason),
        .msg_len_o    (msg_len)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [3:0] len, input logic [63:0] bytes);
        load_bytes = bytes;
        load_len   = len;
        load       = 1'b1;
        step();
        load       = 1'b0;
    endtask

    task automatic do_start();
        phase = PH_MO;
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] exp, input bit is_last, input string tag);
        req = 1'b1;
        step();
        step();
        check({tag, " strobe"}, msg_stb, 1);
        check({tag, " byte"}, msg_byte, exp);
        check({tag, " R5 atn"}, atn, is_last ? 0 : 1);
        ack = 1'b1;
        req = 1'b0;
        step();
        ack = 1'b0;
        check({tag, " R4 strobe one cycle"}, msg_stb, 0);
        check({tag, " R4 byte held"}, msg_byte, exp);
    endtask

    task automatic snoop_end(input logic [2:0] ph, input bit bf,
                             input int exp_reason, input int exp_atn,
                             input int exp_len, input string tag);
        phase   = ph;
        req     = !bf;
        busfree = bf;
        step();
        req     = 1'b0;
        busfree = 1'b0;
        check({tag, " done"}, done, 1);
        check({tag, " reason"}, reason, exp_reason);
        check({tag, " atn"}, atn, exp_atn);
        check({tag, " length"}, msg_len, exp_len);
        step();
        check({tag, " R10 done single cycle"}, done, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        check("R1 atn in reset", atn, 0);
        check("R1 strobe in reset", msg_stb, 0);
        check("R1 done in reset", done, 0);
        check("R1 length in reset", msg_len, 0);
        rst = 1'b0;
        step();
        check("R1 atn after reset", atn, 0);
        check("R1 length after reset", msg_len, 0);
    endtask

    task automatic t_three_sent();
        do_load(4'd3, 64'h0000_0000_00C3_B2A1);
        check("R2 atn after load", atn, 1);
        check("R2 length after load", msg_len, 3);
        do_start();
        send_byte(8'hA1, 0, "R4 three b0");
        send_byte(8'hB2, 0, "R4 three b1");
        send_byte(8'hC3, 1, "R4 three b2");
        snoop_end(PH_MI, 0, 0, 0, 0, "R8 sent");
    endtask

    task automatic t_nop_busfree();
        check("R3 empty before start", msg_len, 0);
        do_start();
        check("R3 length after nop fill", msg_len, 1);
        send_byte(8'h08, 1, "R3 nop byte");
        snoop_end(PH_MO, 1, 2, 0, 0, "R9 bus free");
    endtask

    task automatic t_resend();
        do_load(4'd2, 64'h0000_0000_0000_5A3C);
        do_start();
        send_byte(8'h3C, 0, "R7 first b0");
        send_byte(8'h5A, 1, "R7 first b1");
        snoop_end(PH_MO, 0, 3, 1, 2, "R7 resend");
        do_start();
        send_byte(8'h3C, 0, "R7 again b0");
        send_byte(8'h5A, 1, "R7 again b1");
        snoop_end(PH_MI, 0, 0, 0, 0, "R8 after resend");
    endtask

    task automatic t_mismatch_wait();
        do_load(4'd4, 64'h0000_0000_4433_2211);
        do_start();
        send_byte(8'h11, 0, "R6 wait b0");
        phase = PH_MI;
        step();
        check("R6 wait done", done, 1);
        check("R6 wait reason", reason, 1);
        check("R6 wait atn", atn, 0);
        check("R6 wait length", msg_len, 0);
        req = 1'b1;
        step();
        step();
        check("R6 wait no further strobe", msg_stb, 0);
        req = 1'b0;
        step();
    endtask

    task automatic t_mismatch_issue();
        do_load(4'd2, 64'h0000_0000_0000_7766);
        do_start();
        req = 1'b1;
        step();
        phase = PH_MI;
        step();
        req = 1'b0;
        check("R6 issue no strobe", msg_stb, 0);
        check("R6 issue done", done, 1);
        check("R6 issue reason", reason, 1);
        check("R6 issue atn", atn, 0);
        check("R6 issue length", msg_len, 0);
        step();
    endtask

    task automatic t_clamp_eight();
        logic [63:0] pat;
        pat = 64'h8877_6655_4433_2210;
        do_load(4'd12, pat);
        check("R2 clamped length", msg_len, 8);
        do_start();
        for (int i = 0; i < 8; i++) begin
            send_byte(pat[8*i +: 8], i == 7, $sformatf("R4 clamp b%0d", i));
        end
        snoop_end(PH_MI, 0, 0, 0, 0, "R8 clamp sent");
    endtask

    task automatic t_single_and_restart();
        do_load(4'd1, 64'h0000_0000_0000_00E7);
        check("R2 atn single", atn, 1);
        do_start();
        send_byte(8'hE7, 1, "R5 single byte");
        snoop_end(PH_MI, 0, 0, 0, 0, "R8 single sent");
        do_load(4'd3, 64'h0000_0000_00F3_F2F1);
        do_start();
        send_byte(8'hF1, 0, "R10 busy b0");
        start = 1'b1;
        step();
        start = 1'b0;
        send_byte(8'hF2, 0, "R10 start ignored b1");
        send_byte(8'hF3, 1, "R10 busy b2");
        snoop_end(PH_MI, 0, 0, 0, 0, "R10 sent");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        load       = 1'b0;
        load_len   = '0;
        load_bytes = '0;
        start      = 1'b0;
        phase      = PH_MO;
        req        = 1'b0;
        busfree    = 1'b0;
        ack        = 1'b0;
        @(negedge clk);
        t_reset();
        t_three_sent();
        t_nop_busfree();
        t_resend();
        t_mismatch_wait();
        t_mismatch_issue();
        t_clamp_eight();
        t_single_and_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule